// File: doc/BRIEF.md
# Battery Monitor Register Bank

This block is the byte-wide register file that sits behind the serial command engine of a battery-monitoring front end. The engine presents an 8-bit address with a read or write strobe and marks the end of each command with a strobe. The bank holds a control byte, a general feature byte, a read-only 16-bit current value and a 16-bit accumulated-charge value. The measurement path supplies both 16-bit values live.

A read of the upper byte of either 16-bit value captures the whole pair. A later read of the lower byte in the same command then returns the matching half, even if the live value has moved since. The control byte has two writable bits. One lets a bus-idle timer raise a sleep request once the bus line has been low for a set time. The other picks which opcode the command engine accepts for a network-address read. Host writes to the accumulated-charge bytes come out as a single 16-bit load toward the measurement path.

Top module: `batt_reg_bank`

## Requirements
- R1: After reset the control byte and the feature byte read 00h, `nar_opcode_o` is 33h, and `sleep_req_o` and `acc_load_o` are low.
- R2: Control byte at address 01h: only bit 6 (sleep enable) and bit 5 (alternate opcode) are stored. All other bits read 0, so writing FFh reads back 60h.
- R3: `nar_opcode_o` is 39h while control bit 5 is 1 and 33h while it is 0. It changes the cycle after the write.
- R4: The feature byte at 08h stores and returns all 8 bits.
- R5: Current bytes at 0Eh (upper) and 0Fh (lower) are read-only. Writes there change nothing, and a read of 0Eh returns the live `cur_i[15:8]`.
- R6: Every address other than 01h, 08h, 0Eh, 0Fh, 10h and 11h reads 00h, and writes to such addresses change no register.
- R7: A read of 0Eh or 10h captures both bytes of that pair. A read of 0Fh or 11h later in the same command returns the captured lower byte, whatever the live input does in between.
- R8: `cmd_end_i` releases both captures. A lower-byte read with no upper-byte read since the last `cmd_end_i` returns the live lower byte.
- R9: A write to 10h holds the upper byte. A write to 11h then drives `acc_load_o` high for one cycle, with `acc_wdata_o` = {held upper byte, written byte}, in the cycle after the write.
- R10: With control bit 6 set, once `bus_line_i` has been sampled low on LIMIT = CLK_HZ*IDLE_SEC consecutive clock edges, `sleep_req_o` pulses for exactly one cycle, visible after the LIMIT-th edge. It does not pulse again while the line stays low.
- R11: Any high sample of `bus_line_i` restarts the low-time count from zero. With control bit 6 clear, no sleep request is raised.
- R12: `rdata_o` is registered. It takes the addressed value in the cycle after a read strobe and holds it when there is no read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 8 | Register byte address |
| wdata_i | input | 8 | Write data |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| cmd_end_i | input | 1 | End-of-command strobe, releases captures |
| cur_i | input | 16 | Live current value |
| acc_i | input | 16 | Live accumulated-charge value |
| bus_line_i | input | 1 | Sampled level of the serial bus data line |
| rdata_o | output | 8 | Read data, registered |
| acc_load_o | output | 1 | One-cycle load pulse for a host accumulator write |
| acc_wdata_o | output | 16 | Value to load into the accumulator |
| sleep_req_o | output | 1 | One-cycle sleep request after the bus has idled low |
| nar_opcode_o | output | 8 | Accepted network-address read opcode |

## Verification
The hardest case to reach is a capture that actually matters: the live value must change between the upper-byte read and the lower-byte read of one command. Otherwise a design that simply returns live data would look correct. The stimulus changes `cur_i` and `acc_i` at random between reads and ends commands at random points, and a bench model of each capture's hold state predicts every lower-byte read. Directed cases cover the bus-idle timer on a shortened LIMIT: a high glitch just short of expiry, and the expiry itself, with the pulse counted cycle by cycle.

// File: rtl/regbank_pkg.sv
package regbank_pkg;
  localparam logic [7:0] ADDR_CTRL   = 8'h01;
  localparam logic [7:0] ADDR_FEAT   = 8'h08;
  localparam logic [7:0] ADDR_CUR_HI = 8'h0E;
  localparam logic [7:0] ADDR_CUR_LO = 8'h0F;
  localparam logic [7:0] ADDR_ACC_HI = 8'h10;
  localparam logic [7:0] ADDR_ACC_LO = 8'h11;
  localparam logic [7:0] OPC_BASE    = 8'h33;
  localparam logic [7:0] OPC_ALT     = 8'h39;
  localparam int unsigned CTRL_SLEEP_BIT = 6;
  localparam int unsigned CTRL_OPC_BIT   = 5;

  function automatic logic is_mapped(input logic [7:0] a);
    return a == ADDR_CTRL || a == ADDR_FEAT || a == ADDR_CUR_HI ||
           a == ADDR_CUR_LO || a == ADDR_ACC_HI || a == ADDR_ACC_LO;
  endfunction
endpackage

// File: rtl/regbank_snap.sv
module regbank_snap #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] live_i,
  input  logic         latch_i,
  input  logic         release_i,
  output logic         held_o,
  output logic [W-1:0] snap_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      held_o <= 1'b0;
      snap_o <= '0;
    end else if (release_i) begin
      held_o <= 1'b0;
    end else if (latch_i) begin
      held_o <= 1'b1;
      snap_o <= live_i;
    end
  end
endmodule

// File: rtl/regbank_idle_timer.sv
module regbank_idle_timer #(
  parameter int unsigned LIMIT = 65536
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic line_i,
  output logic req_o
);
  localparam int unsigned CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] CNT_MAX  = CW'(LIMIT);
  localparam logic [CW-1:0] CNT_LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q;

  // saturates at LIMIT so the request fires once per low period
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      req_o <= 1'b0;
    end else begin
      req_o <= 1'b0;
      if (line_i) begin
        cnt_q <= '0;
      end else if (cnt_q != CNT_MAX) begin
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == CNT_LAST) req_o <= en_i;
      end
    end
  end
endmodule

// File: rtl/regbank_ctrl.sv
module regbank_ctrl
  import regbank_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_i,
  input  logic [7:0]      addr_i,
  input  logic [DW-1:0]   wdata_i,
  output logic            sleep_en_o,
  output logic            alt_opc_o,
  output logic [DW-1:0]   feat_o,
  output logic            acc_load_o,
  output logic [2*DW-1:0] acc_wdata_o
);
  logic [DW-1:0] acc_hi_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sleep_en_o  <= 1'b0;
      alt_opc_o   <= 1'b0;
      feat_o      <= '0;
      acc_hi_q    <= '0;
      acc_load_o  <= 1'b0;
      acc_wdata_o <= '0;
    end else begin
      acc_load_o <= 1'b0;
      if (wr_i) begin
        unique case (addr_i)
          ADDR_CTRL: begin
            sleep_en_o <= wdata_i[CTRL_SLEEP_BIT];
            alt_opc_o  <= wdata_i[CTRL_OPC_BIT];
          end
          ADDR_FEAT:   feat_o   <= wdata_i;
          ADDR_ACC_HI: acc_hi_q <= wdata_i;
          ADDR_ACC_LO: begin
            acc_load_o  <= 1'b1;
            acc_wdata_o <= {acc_hi_q, wdata_i};
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/batt_reg_bank.sv
module batt_reg_bank
  import regbank_pkg::*;
#(
  parameter int unsigned CLK_HZ   = 32768,
  parameter int unsigned IDLE_SEC = 2
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [7:0]  addr_i,
  input  logic [7:0]  wdata_i,
  input  logic        wr_i,
  input  logic        rd_i,
  input  logic        cmd_end_i,
  input  logic [15:0] cur_i,
  input  logic [15:0] acc_i,
  input  logic        bus_line_i,
  output logic [7:0]  rdata_o,
  output logic        acc_load_o,
  output logic [15:0] acc_wdata_o,
  output logic        sleep_req_o,
  output logic [7:0]  nar_opcode_o
);
  localparam int unsigned DW    = 8;
  localparam int unsigned NPAIR = 2;
  localparam int unsigned LIMIT = CLK_HZ * IDLE_SEC;

  logic          sleep_en, alt_opc;
  logic [DW-1:0] feat;

  logic [NPAIR-1:0][2*DW-1:0] pair_live, pair_snap;
  logic [NPAIR-1:0][7:0]      pair_hi_addr;
  logic [NPAIR-1:0]           pair_held;

  assign pair_live    = {acc_i, cur_i};
  assign pair_hi_addr = {ADDR_ACC_HI, ADDR_CUR_HI};

  regbank_ctrl #(.DW(DW)) u_ctrl (
    .clk_i, .rst_ni, .wr_i, .addr_i, .wdata_i,
    .sleep_en_o (sleep_en),
    .alt_opc_o  (alt_opc),
    .feat_o     (feat),
    .acc_load_o, .acc_wdata_o
  );

  for (genvar g = 0; g < NPAIR; g++) begin : g_pair
    regbank_snap #(.W(2*DW)) u_snap (
      .clk_i, .rst_ni,
      .live_i    (pair_live[g]),
      .latch_i   (rd_i && addr_i == pair_hi_addr[g]),
      .release_i (cmd_end_i),
      .held_o    (pair_held[g]),
      .snap_o    (pair_snap[g])
    );
  end

  regbank_idle_timer #(.LIMIT(LIMIT)) u_idle (
    .clk_i, .rst_ni,
    .en_i   (sleep_en),
    .line_i (bus_line_i),
    .req_o  (sleep_req_o)
  );

  assign nar_opcode_o = alt_opc ? OPC_ALT : OPC_BASE;

  logic [DW-1:0] rd_val;
  always_comb begin
    unique case (addr_i)
      ADDR_CTRL:   rd_val = {1'b0, sleep_en, alt_opc, 5'b0};
      ADDR_FEAT:   rd_val = feat;
      ADDR_CUR_HI: rd_val = cur_i[15:8];
      ADDR_CUR_LO: rd_val = pair_held[0] ? pair_snap[0][7:0] : cur_i[7:0];
      ADDR_ACC_HI: rd_val = acc_i[15:8];
      ADDR_ACC_LO: rd_val = pair_held[1] ? pair_snap[1][7:0] : acc_i[7:0];
      default:     rd_val = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_o <= '0;
    else if (rd_i) rdata_o <= rd_val;
  end
endmodule

// File: rtl/regbank_chk.sv
module regbank_chk
  import regbank_pkg::*;
(
  input logic        clk_i,
  input logic        rst_ni,
  input logic [7:0]  addr_i,
  input logic [7:0]  wdata_i,
  input logic        wr_i,
  input logic        rd_i,
  input logic [15:0] cur_i,
  input logic        bus_line_i,
  input logic [7:0]  rdata_o,
  input logic        acc_load_o,
  input logic        sleep_req_o,
  input logic [7:0]  nar_opcode_o
);
  a_r3_opcode_follows_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == ADDR_CTRL) |=>
      nar_opcode_o == ($past(wdata_i[CTRL_OPC_BIT]) ? OPC_ALT : OPC_BASE));

  a_r2_ctrl_reserved_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && addr_i == ADDR_CTRL) |=> (rdata_o[7] == 1'b0 && rdata_o[4:0] == 5'b0));

  a_r6_unmapped_reads_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !is_mapped(addr_i)) |=> rdata_o == 8'h00);

  a_r7_upper_read_live: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && addr_i == ADDR_CUR_HI) |=> rdata_o == $past(cur_i[15:8]));

  a_r9_load_after_lo_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_load_o |-> $past(wr_i && addr_i == ADDR_ACC_LO));

  a_r10_sleep_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_req_o |=> !sleep_req_o);

  a_r11_sleep_needs_low_line: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_req_o |-> $past(!bus_line_i));

  a_r12_rdata_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> $stable(rdata_o));
endmodule

bind batt_reg_bank regbank_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .addr_i       (addr_i),
  .wdata_i      (wdata_i),
  .wr_i         (wr_i),
  .rd_i         (rd_i),
  .cur_i        (cur_i),
  .bus_line_i   (bus_line_i),
  .rdata_o      (rdata_o),
  .acc_load_o   (acc_load_o),
  .sleep_req_o  (sleep_req_o),
  .nar_opcode_o (nar_opcode_o)
);

// File: tb/tb_batt_reg_bank.sv
module tb_batt_reg_bank;
  localparam int CLK_PERIOD = 10;
  localparam int unsigned CLK_HZ = 16;
  localparam int unsigned IDLE_SEC = 2;
  localparam int unsigned LIMIT = CLK_HZ * IDLE_SEC;

  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic [7:0]  addr_i = '0, wdata_i = '0;
  logic        wr_i = 1'b0, rd_i = 1'b0, cmd_end_i = 1'b0;
  logic [15:0] cur_i = '0, acc_i = '0;
  logic        bus_line_i = 1'b1;
  logic [7:0]  rdata_o;
  logic        acc_load_o;
  logic [15:0] acc_wdata_o;
  logic        sleep_req_o;
  logic [7:0]  nar_opcode_o;

  batt_reg_bank #(.CLK_HZ(CLK_HZ), .IDLE_SEC(IDLE_SEC)) dut (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  int checks = 0, failures = 0;
  bit done = 0;

  // bench model
  logic [7:0]  m_ctrl = 8'h00, m_feat = 8'h00, m_acc_hi = 8'h00;
  bit          m_held_c = 0, m_held_a = 0;
  logic [15:0] m_snap_c = '0, m_snap_a = '0;

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_opc(input logic [7:0] ctrl);
    return ctrl[5] ? 8'h39 : 8'h33;
  endfunction

  function automatic string tag_of(input logic [7:0] a);
    case (a)
      8'h01: return "R2";
      8'h08: return "R4";
      8'h0E, 8'h10: return "R7";
      8'h0F, 8'h11: return "R8";
      default: return "R6";
    endcase
  endfunction

  task automatic do_wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk_i);
    addr_i = a; wdata_i = d; wr_i = 1'b1;
    @(negedge clk_i);
    wr_i = 1'b0;
    case (a)
      8'h01: m_ctrl = d & 8'h60;
      8'h08: m_feat = d;
      8'h10: m_acc_hi = d;
      default: ;
    endcase
    if (a == 8'h11) begin
      chk("R9 load pulse", {15'd0, acc_load_o}, 16'd1);
      chk("R9 load value", acc_wdata_o, {m_acc_hi, d});
    end else begin
      chk("R9 no load", {15'd0, acc_load_o}, 16'd0);
    end
    chk("R3 opcode", {8'd0, nar_opcode_o}, {8'd0, exp_opc(m_ctrl)});
  endtask

  task automatic do_rd(input logic [7:0] a);
    logic [7:0] e;
    case (a)
      8'h01: e = m_ctrl;
      8'h08: e = m_feat;
      8'h0E: begin e = cur_i[15:8]; m_snap_c = cur_i; m_held_c = 1; end
      8'h0F: e = m_held_c ? m_snap_c[7:0] : cur_i[7:0];
      8'h10: begin e = acc_i[15:8]; m_snap_a = acc_i; m_held_a = 1; end
      8'h11: e = m_held_a ? m_snap_a[7:0] : acc_i[7:0];
      default: e = 8'h00;
    endcase
    @(negedge clk_i);
    addr_i = a; rd_i = 1'b1;
    @(negedge clk_i);
    rd_i = 1'b0;
    chk(tag_of(a), {8'd0, rdata_o}, {8'd0, e});
  endtask

  task automatic end_cmd();
    @(negedge clk_i);
    cmd_end_i = 1'b1;
    @(negedge clk_i);
    cmd_end_i = 1'b0;
    m_held_c = 0; m_held_a = 0;
  endtask

  // hold line low n cycles; count pulses and the cycle of the first
  task automatic run_low(input int n, output int pulses, output int first);
    pulses = 0; first = -1;
    bus_line_i = 1'b0;
    for (int i = 1; i <= n; i++) begin
      @(negedge clk_i);
      if (sleep_req_o) begin
        pulses++;
        if (first < 0) first = i;
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int p, f;
    logic [7:0] held;
    void'($urandom(32'd20250611));
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R1 reset state
    chk("R1 opcode", {8'd0, nar_opcode_o}, 16'h0033);
    chk("R1 sleep", {15'd0, sleep_req_o}, 16'd0);
    chk("R1 load", {15'd0, acc_load_o}, 16'd0);
    do_rd(8'h01);
    do_rd(8'h08);

    // R2 / R3
    do_wr(8'h01, 8'hFF); do_rd(8'h01);
    do_wr(8'h01, 8'h20); do_rd(8'h01);
    do_wr(8'h01, 8'h00);
    // R4
    do_wr(8'h08, 8'hA5); do_rd(8'h08);
    // R5 read-only current
    cur_i = 16'h1234;
    do_wr(8'h0E, 8'hFF); do_wr(8'h0F, 8'hFF);
    do_rd(8'h0E); end_cmd(); do_rd(8'h0F);
    // R6 reserved write leaves mapped regs alone
    do_wr(8'h00, 8'hFF); do_wr(8'h81, 8'h60); do_wr(8'hFF, 8'h3C);
    do_rd(8'h00); do_rd(8'hC3); do_rd(8'h01); do_rd(8'h08);

    // R7 capture, R8 release
    cur_i = 16'h12_34; do_rd(8'h0E);
    cur_i = 16'hAB_CD; do_rd(8'h0F);
    end_cmd(); do_rd(8'h0F);
    acc_i = 16'h55_66; do_rd(8'h10);
    acc_i = 16'h77_88; do_rd(8'h11);
    end_cmd(); do_rd(8'h11);

    // R12 hold without read
    do_rd(8'h08);
    held = rdata_o;
    cur_i = 16'hFFFF; addr_i = 8'h0E;
    repeat (3) @(negedge clk_i);
    chk("R12 hold", {8'd0, rdata_o}, {8'd0, held});

    // R9 host accumulator write
    do_wr(8'h10, 8'hA5); do_wr(8'h11, 8'h3C);

    // random mix
    for (int k = 0; k < 200; k++) begin
      int op;
      logic [7:0] a;
      op = $urandom_range(0, 5);
      case (op)
        0: do_wr(8'h01, 8'($urandom));
        1: do_wr(8'h08, 8'($urandom));
        2: begin
          a = ($urandom_range(0, 1) == 0) ? 8'($urandom) : 8'($urandom_range(8'h0E, 8'h11));
          do_wr(a, 8'($urandom));
        end
        3: begin
          case ($urandom_range(0, 6))
            0: a = 8'h01; 1: a = 8'h08; 2: a = 8'h0E; 3: a = 8'h0F;
            4: a = 8'h10; 5: a = 8'h11; default: a = 8'($urandom);
          endcase
          do_rd(a);
        end
        4: begin
          @(negedge clk_i);
          cur_i = 16'($urandom); acc_i = 16'($urandom);
        end
        default: end_cmd();
      endcase
    end

    // R10 sleep request timing
    do_wr(8'h01, 8'h40);
    bus_line_i = 1'b1; @(negedge clk_i);
    run_low(LIMIT + 20, p, f);
    chk("R10 pulse count", 16'(p), 16'd1);
    chk("R10 pulse cycle", 16'(f), 16'(LIMIT));
    // R11 restart on high glitch
    bus_line_i = 1'b1; @(negedge clk_i);
    run_low(LIMIT - 3, p, f);
    bus_line_i = 1'b1; @(negedge clk_i);
    run_low(LIMIT - 1, p, f);
    chk("R11 restart no pulse", 16'(p), 16'd0);
    run_low(5, p, f);
    chk("R11 pulse after restart", 16'(p), 16'd1);
    chk("R11 pulse after restart cycle", 16'(f), 16'd1);
    // R11 disabled
    do_wr(8'h01, 8'h00);
    bus_line_i = 1'b1; @(negedge clk_i);
    run_low(2 * LIMIT + 4, p, f);
    chk("R11 disabled no pulse", 16'(p), 16'd0);
    bus_line_i = 1'b1;

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule